// File: doc/BRIEF.md
# Accumulator CPU Instruction Sequencer

This block is the control core of a small 8-bit machine with two working registers: an accumulator A and an extension register B. It keeps an 8-bit program counter and a carry flag and a zero flag. It pulls opcode and operand bytes from a synchronous program memory and reads or writes a separate, synchronous data memory. Each instruction passes through a fixed sequence of states: FETCH, DECODE, an optional OPERAND, EXECUTE and, for loads from data memory, WRITEBACK. Arithmetic and logic are delegated to an ALU submodule over a function/operand/result interface.

Each opcode is one byte. Jumps, loads and stores carry one extra operand byte directly after the opcode. Both memories return data one clock after the address is presented. The architectural registers are brought out on ports, so the surrounding system can observe the machine state.

Top module: `acc_cpu_core`

## Requirements
- R1: While synchronous reset is high the program counter, A, B, carry and zero read 0, and the program address output is 0.
- R2: An instruction with no operand byte takes 3 cycles. Jumps, immediate loads and stores take 4 cycles, and loads from data memory take 5. The store write strobe is high in the fourth cycle of the store.
- R3: NOP (0x00) changes no register, no flag and no memory; it only moves the program counter past itself.
- R4: Immediate loads place the byte after the opcode into A (0x20) or into B (0x21).
- R5: Direct loads place data memory[operand] into A (0x22) or into B (0x23).
- R6: Store (0x24) writes A to data memory[operand] with a write strobe one cycle long.
- R7: JMP (0x10) sets the program counter to the operand byte.
- R8: JC (0x11) branches only when carry is 1, and JZ (0x12) branches only when zero is 1. A jump that is not taken continues at the instruction after the operand.
- R9: NOT (0x01, ~A), AND (0x02), XOR (0x03) and OR (0x04) of A with B write A, clear carry, and set zero exactly when the result is 0.
- R10: SHL (0x05) shifts A left with a 0 in bit 0. ROL (0x06) shifts A left with the old carry in bit 0. In both cases carry takes the old A bit 7, and zero reflects the result.
- R11: ADD (0x07) writes A+B and ADC (0x08) writes A+B+carry, both modulo 256. Carry takes the bit-8 carry out, and zero reflects the result.
- R12: Loads, stores, jumps and NOP leave carry and zero unchanged.
- R13: Any opcode not listed above behaves exactly like NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr_o | output | 8 | Program memory address |
| prog_data_i | input | 8 | Program memory byte, one cycle after its address |
| dmem_addr_o | output | 8 | Data memory address |
| dmem_wdata_o | output | 8 | Data memory write byte |
| dmem_we_o | output | 1 | Data memory write strobe |
| dmem_rdata_i | input | 8 | Data memory byte, one cycle after its address |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator A |
| ext_o | output | 8 | Extension register B |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
Cycle 0 is the first cycle after reset is released, and the first instruction starts there. Each later instruction starts after the 3, 4 or 5 cycles its predecessor costs, so the store strobe of a known program is expected in one exact cycle, and the bench samples it there at the falling edge. Register and flag results are read only after the program has reached a jump-to-self loop, which changes no register or flag, so those checks do not depend on sampling phase. The ALU expectations come from arithmetic in the bench over a grid of operand pairs, with carry-in both 0 and 1.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [2:0] {
      ST_FETCH, ST_DECODE, ST_OPERAND, ST_EXECUTE, ST_WRITEBACK
   } seq_state_t;

   typedef enum logic [3:0] {
      FN_PASS, FN_NOT, FN_AND, FN_XOR, FN_OR, FN_SHL, FN_ROL, FN_ADD, FN_ADC
   } alu_fn_t;

   typedef enum logic [2:0] {
      K_NONE, K_ALU, K_JUMP, K_LDIMM, K_LDMEM, K_STORE
   } instr_kind_t;

   typedef enum logic [1:0] {
      JC_ALWAYS, JC_CARRY, JC_ZERO
   } jump_cond_t;

   typedef struct packed {
      instr_kind_t kind;
      alu_fn_t     fn;
      logic        to_ext;
      jump_cond_t  cond;
      logic        has_opnd;
   } ctrl_t;

   localparam logic [7:0] OP_NOP  = 8'h00;
   localparam logic [7:0] OP_NOT  = 8'h01;
   localparam logic [7:0] OP_AND  = 8'h02;
   localparam logic [7:0] OP_XOR  = 8'h03;
   localparam logic [7:0] OP_OR   = 8'h04;
   localparam logic [7:0] OP_SHL  = 8'h05;
   localparam logic [7:0] OP_ROL  = 8'h06;
   localparam logic [7:0] OP_ADD  = 8'h07;
   localparam logic [7:0] OP_ADC  = 8'h08;
   localparam logic [7:0] OP_JMP  = 8'h10;
   localparam logic [7:0] OP_JC   = 8'h11;
   localparam logic [7:0] OP_JZ   = 8'h12;
   localparam logic [7:0] OP_LDAI = 8'h20;
   localparam logic [7:0] OP_LDBI = 8'h21;
   localparam logic [7:0] OP_LDAM = 8'h22;
   localparam logic [7:0] OP_LDBM = 8'h23;
   localparam logic [7:0] OP_STA  = 8'h24;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opcode_i,
   output ctrl_t             ctrl_o
);

   always_comb begin
      ctrl_o = '{kind: K_NONE, fn: FN_PASS, to_ext: 1'b0,
                 cond: JC_ALWAYS, has_opnd: 1'b0};
      case (opcode_i)
         DATA_W'(OP_NOT):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_NOT; end
         DATA_W'(OP_AND):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_AND; end
         DATA_W'(OP_XOR):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_XOR; end
         DATA_W'(OP_OR):   begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_OR;  end
         DATA_W'(OP_SHL):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_SHL; end
         DATA_W'(OP_ROL):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_ROL; end
         DATA_W'(OP_ADD):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_ADD; end
         DATA_W'(OP_ADC):  begin ctrl_o.kind = K_ALU; ctrl_o.fn = FN_ADC; end
         DATA_W'(OP_JMP):  begin ctrl_o.kind = K_JUMP; ctrl_o.has_opnd = 1'b1; end
         DATA_W'(OP_JC):   begin
            ctrl_o.kind = K_JUMP; ctrl_o.cond = JC_CARRY; ctrl_o.has_opnd = 1'b1;
         end
         DATA_W'(OP_JZ):   begin
            ctrl_o.kind = K_JUMP; ctrl_o.cond = JC_ZERO; ctrl_o.has_opnd = 1'b1;
         end
         DATA_W'(OP_LDAI): begin ctrl_o.kind = K_LDIMM; ctrl_o.has_opnd = 1'b1; end
         DATA_W'(OP_LDBI): begin
            ctrl_o.kind = K_LDIMM; ctrl_o.to_ext = 1'b1; ctrl_o.has_opnd = 1'b1;
         end
         DATA_W'(OP_LDAM): begin ctrl_o.kind = K_LDMEM; ctrl_o.has_opnd = 1'b1; end
         DATA_W'(OP_LDBM): begin
            ctrl_o.kind = K_LDMEM; ctrl_o.to_ext = 1'b1; ctrl_o.has_opnd = 1'b1;
         end
         DATA_W'(OP_STA):  begin ctrl_o.kind = K_STORE; ctrl_o.has_opnd = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  alu_fn_t           fn_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              cin_i,
   output logic [DATA_W-1:0] res_o,
   output logic              cout_o,
   output logic              zero_o
);

   localparam int MSB = DATA_W - 1;

   logic              add_cin;
   logic [DATA_W-1:0] sum;
   logic              sum_cout;

   assign add_cin = (fn_i == FN_ADC) ? cin_i : 1'b0;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = add_cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_fa
            assign sum[i]  = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign sum_cout = cy[DATA_W];
      end else begin : g_infer
         assign {sum_cout, sum} = {1'b0, a_i} + {1'b0, b_i} + (DATA_W+1)'(add_cin);
      end
   endgenerate

   always_comb begin
      res_o  = a_i;
      cout_o = cin_i;
      case (fn_i)
         FN_NOT: begin res_o = ~a_i;       cout_o = 1'b0; end
         FN_AND: begin res_o = a_i & b_i;  cout_o = 1'b0; end
         FN_XOR: begin res_o = a_i ^ b_i;  cout_o = 1'b0; end
         FN_OR:  begin res_o = a_i | b_i;  cout_o = 1'b0; end
         FN_SHL: begin res_o = {a_i[MSB-1:0], 1'b0};  cout_o = a_i[MSB]; end
         FN_ROL: begin res_o = {a_i[MSB-1:0], cin_i}; cout_o = a_i[MSB]; end
         FN_ADD, FN_ADC: begin res_o = sum; cout_o = sum_cout; end
         default: ;
      endcase
   end

   assign zero_o = (res_o == '0);

endmodule

// File: rtl/acc_seq.sv
module acc_seq
   import acc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] prog_data_i,
   input  logic [DATA_W-1:0] dmem_rdata_i,
   input  ctrl_t             ctrl_dec_i,
   input  logic [DATA_W-1:0] alu_res_i,
   input  logic              alu_cout_i,
   input  logic              alu_zero_i,
   output alu_fn_t           alu_fn_o,
   output logic [ADDR_W-1:0] prog_addr_o,
   output logic [ADDR_W-1:0] dmem_addr_o,
   output logic [DATA_W-1:0] dmem_wdata_o,
   output logic              dmem_we_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] ext_o,
   output logic              carry_o,
   output logic              zero_o
);

   seq_state_t        st_q;
   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q, ext_q;
   logic              carry_q, zero_q;
   logic              taken;

   always_comb begin
      case (ctrl_q.cond)
         JC_CARRY: taken = carry_q;
         JC_ZERO:  taken = zero_q;
         default:  taken = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_FETCH;
         ctrl_q  <= '{kind: K_NONE, fn: FN_PASS, to_ext: 1'b0,
                      cond: JC_ALWAYS, has_opnd: 1'b0};
         pc_q    <= '0;
         acc_q   <= '0;
         ext_q   <= '0;
         carry_q <= 1'b0;
         zero_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_FETCH: st_q <= ST_DECODE;
            ST_DECODE: begin
               ctrl_q <= ctrl_dec_i;
               pc_q   <= pc_q + 1'b1;
               st_q   <= ctrl_dec_i.has_opnd ? ST_OPERAND : ST_EXECUTE;
            end
            ST_OPERAND: begin
               pc_q <= pc_q + 1'b1;
               st_q <= ST_EXECUTE;
            end
            ST_EXECUTE: begin
               st_q <= ST_FETCH;
               case (ctrl_q.kind)
                  K_ALU: begin
                     acc_q   <= alu_res_i;
                     carry_q <= alu_cout_i;
                     zero_q  <= alu_zero_i;
                  end
                  K_JUMP: if (taken) pc_q <= prog_data_i[ADDR_W-1:0];
                  K_LDIMM: begin
                     if (ctrl_q.to_ext) ext_q <= prog_data_i;
                     else               acc_q <= prog_data_i;
                  end
                  K_LDMEM: st_q <= ST_WRITEBACK;
                  default: ;
               endcase
            end
            ST_WRITEBACK: begin
               if (ctrl_q.to_ext) ext_q <= dmem_rdata_i;
               else               acc_q <= dmem_rdata_i;
               st_q <= ST_FETCH;
            end
            default: st_q <= ST_FETCH;
         endcase
      end
   end

   assign alu_fn_o     = ctrl_q.fn;
   assign prog_addr_o  = pc_q;
   assign dmem_addr_o  = prog_data_i[ADDR_W-1:0];
   assign dmem_wdata_o = acc_q;
   assign dmem_we_o    = (st_q == ST_EXECUTE) && (ctrl_q.kind == K_STORE);
   assign pc_o         = pc_q;
   assign acc_o        = acc_q;
   assign ext_o        = ext_q;
   assign carry_o      = carry_q;
   assign zero_o       = zero_q;

   // R6
   store_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      dmem_we_o |=> !dmem_we_o);

   // R12
   flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q != ST_EXECUTE || ctrl_q.kind != K_ALU) |=> $stable({carry_q, zero_q}));

   // R11
   zero_track_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_EXECUTE && ctrl_q.kind == K_ALU) |=> (zero_q == (acc_q == '0)));

   // R2
   pc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_FETCH || st_q == ST_WRITEBACK) |=> $stable(pc_q));

   // R5
   wb_order_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_WRITEBACK) |-> ($past(st_q) == ST_EXECUTE));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] prog_addr_o,
   input  logic [DATA_W-1:0] prog_data_i,
   output logic [ADDR_W-1:0] dmem_addr_o,
   output logic [DATA_W-1:0] dmem_wdata_o,
   output logic              dmem_we_o,
   input  logic [DATA_W-1:0] dmem_rdata_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] ext_o,
   output logic              carry_o,
   output logic              zero_o
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("acc_cpu_core: DATA_W must hold a one-byte opcode");
      end
      if (ADDR_W > DATA_W || ADDR_W < 1) begin : g_bad_addr_w
         $error("acc_cpu_core: ADDR_W must fit in one operand word");
      end
   endgenerate

   ctrl_t             ctrl_dec;
   alu_fn_t           alu_fn;
   logic [DATA_W-1:0] alu_res;
   logic              alu_cout, alu_zero;

   acc_decode #(.DATA_W(DATA_W)) i_decode (
      .opcode_i (prog_data_i),
      .ctrl_o   (ctrl_dec)
   );

   acc_alu #(.DATA_W(DATA_W), .RIPPLE_ADD(RIPPLE_ADD)) i_alu (
      .fn_i   (alu_fn),
      .a_i    (acc_o),
      .b_i    (ext_o),
      .cin_i  (carry_o),
      .res_o  (alu_res),
      .cout_o (alu_cout),
      .zero_o (alu_zero)
   );

   acc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
      .clk          (clk),
      .rst          (rst),
      .prog_data_i  (prog_data_i),
      .dmem_rdata_i (dmem_rdata_i),
      .ctrl_dec_i   (ctrl_dec),
      .alu_res_i    (alu_res),
      .alu_cout_i   (alu_cout),
      .alu_zero_i   (alu_zero),
      .alu_fn_o     (alu_fn),
      .prog_addr_o  (prog_addr_o),
      .dmem_addr_o  (dmem_addr_o),
      .dmem_wdata_o (dmem_wdata_o),
      .dmem_we_o    (dmem_we_o),
      .pc_o         (pc_o),
      .acc_o        (acc_o),
      .ext_o        (ext_o),
      .carry_o      (carry_o),
      .zero_o       (zero_o)
   );

endmodule

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] prog_addr, prog_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic       dmem_we;
   logic [7:0] pc, acc, ext;
   logic       carry, zero;

   logic [7:0] pmem [256];
   logic [7:0] dmem [256];
   int         pp;
   int         n_checks = 0;
   int         n_fail   = 0;
   int         n_writes = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_cpu_core i_acc_cpu_core (
      .clk (clk), .rst (rst),
      .prog_addr_o (prog_addr), .prog_data_i (prog_data),
      .dmem_addr_o (dmem_addr), .dmem_wdata_o (dmem_wdata),
      .dmem_we_o (dmem_we), .dmem_rdata_i (dmem_rdata),
      .pc_o (pc), .acc_o (acc), .ext_o (ext),
      .carry_o (carry), .zero_o (zero)
   );

   always @(posedge clk) begin
      prog_data  <= pmem[prog_addr];
      dmem_rdata <= dmem[dmem_addr];
      if (dmem_we) begin
         dmem[dmem_addr] <= dmem_wdata;
         n_writes++;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic emit(input logic [7:0] b);
      pmem[pp[7:0]] = b;
      pp++;
   endtask

   task automatic place(input int at);
      pp = at;
   endtask

   task automatic new_prog();
      @(negedge clk);
      rst = 1'b1;
      for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
      pp = 0;
      n_writes = 0;
   endtask

   task automatic go(input int ncyc);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      repeat (ncyc) @(negedge clk);
   endtask

   task automatic halt();
      emit(8'h10);
      emit(8'(pp - 1));
   endtask

   task automatic set_carry();
      emit(8'h20); emit(8'hFF);
      emit(8'h21); emit(8'h01);
      emit(8'h07);
   endtask

   function automatic logic [9:0] model(input int op, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci);
      logic [8:0] s;
      logic [7:0] r;
      logic       c;
      case (op)
         1: begin r = ~a;    c = 1'b0; end
         2: begin r = a & b; c = 1'b0; end
         3: begin r = a ^ b; c = 1'b0; end
         4: begin r = a | b; c = 1'b0; end
         5: begin r = {a[6:0], 1'b0}; c = a[7]; end
         6: begin r = {a[6:0], ci};   c = a[7]; end
         7: begin s = {1'b0, a} + {1'b0, b};              r = s[7:0]; c = s[8]; end
         default: begin s = {1'b0, a} + {1'b0, b} + 9'(ci); r = s[7:0]; c = s[8]; end
      endcase
      return {c, (r == 8'h00), r};
   endfunction

   function automatic logic [7:0] pick(input int i);
      case (i)
         0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'h80;
         4: return 8'hFF; 5: return 8'h55; 6: return 8'hAA; default: return 8'hC3;
      endcase
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin pmem[i] = 8'h00; dmem[i] = 8'h00; end

      // R1: leave non-zero state, then hold reset and look at the ports
      new_prog();
      set_carry();
      emit(8'h21); emit(8'h3C);
      halt();
      go(30);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1 pc", pc, 0);
      chk("R1 acc", acc, 0);
      chk("R1 ext", ext, 0);
      chk("R1 carry", carry, 0);
      chk("R1 zero", zero, 0);
      chk("R1 prog_addr", prog_addr, 0);

      // R4 R12 R3: load with flags set, then NOP keeps everything
      new_prog();
      set_carry();
      emit(8'h20); emit(8'h5A);
      emit(8'h21); emit(8'hC3);
      emit(8'h00);
      halt();
      go(40);
      chk("R4 acc imm", acc, 8'h5A);
      chk("R4 ext imm", ext, 8'hC3);
      chk("R12 carry kept over loads and NOP", carry, 1);
      chk("R12 zero kept over loads and NOP", zero, 1);
      chk("R3 no memory write", n_writes, 0);

      // R13: undefined opcodes act as NOP
      new_prog();
      set_carry();
      emit(8'h20); emit(8'h96);
      emit(8'h21); emit(8'h69);
      emit(8'h3F); emit(8'h13); emit(8'hFF);
      halt();
      go(50);
      chk("R13 acc", acc, 8'h96);
      chk("R13 ext", ext, 8'h69);
      chk("R13 carry", carry, 1);
      chk("R13 zero", zero, 1);
      chk("R13 no write", n_writes, 0);

      // R5: direct loads from data memory, flags untouched
      new_prog();
      dmem[8'h33] = 8'h9E;
      dmem[8'h34] = 8'h17;
      emit(8'h22); emit(8'h33);
      emit(8'h23); emit(8'h34);
      halt();
      go(30);
      chk("R5 acc mem", acc, 8'h9E);
      chk("R5 ext mem", ext, 8'h17);
      chk("R12 flags after mem loads", {carry, zero}, 0);

      // R7 R8: carry and zero clear, conditional jumps fall through
      new_prog();
      emit(8'h10); emit(8'h20);
      place(8'h20);
      emit(8'h11); emit(8'h30);
      emit(8'h12); emit(8'h40);
      emit(8'h20); emit(8'h11);
      halt();
      place(8'h30); emit(8'h20); emit(8'hEE); halt();
      place(8'h40); emit(8'h20); emit(8'h77); halt();
      go(40);
      chk("R7 R8 fall through", acc, 8'h11);

      // R8: carry set (zero set too): JC taken
      new_prog();
      set_carry();
      emit(8'h11); emit(8'h30);
      emit(8'h20); emit(8'h11);
      halt();
      place(8'h30); emit(8'h20); emit(8'hEE); halt();
      go(40);
      chk("R8 JC taken", acc, 8'hEE);

      // R8: only zero set: JC falls through, JZ taken
      new_prog();
      emit(8'h07);
      emit(8'h11); emit(8'h30);
      emit(8'h12); emit(8'h40);
      emit(8'h20); emit(8'h11);
      halt();
      place(8'h30); emit(8'h20); emit(8'hEE); halt();
      place(8'h40); emit(8'h20); emit(8'h77); halt();
      go(40);
      chk("R8 JZ taken after JC not", acc, 8'h77);
      chk("R12 flags after jumps", {carry, zero}, 2'b01);

      // R2 R6: NOP, LDAI, LDAM, STA -> strobe in cycle 3+4+5+3 = 15
      new_prog();
      dmem[8'h10] = 8'h6B;
      emit(8'h00);
      emit(8'h20); emit(8'h05);
      emit(8'h22); emit(8'h10);
      emit(8'h24); emit(8'h20);
      halt();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      begin
         int first = -1;
         int hi = 0;
         for (int c = 0; c < 30; c++) begin
            if (dmem_we) begin
               hi++;
               if (first < 0) first = c;
            end
            @(negedge clk);
         end
         chk("R2 store strobe cycle", first, 15);
         chk("R6 strobe length", hi, 1);
      end
      chk("R6 stored byte", dmem[8'h20], 8'h6B);

      // R9 R10 R11 R6: sweep ALU ops over operand grid and carry-in
      for (int op = 1; op <= 8; op++) begin
         for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  logic [9:0] e;
                  string      tag;
                  e = model(op, pick(ia), pick(ib), ci[0]);
                  tag = (op <= 4) ? "R9" : (op <= 6) ? "R10" : "R11";
                  new_prog();
                  dmem[8'h40] = 8'h00;
                  if (ci == 1) set_carry();
                  emit(8'h20); emit(pick(ia));
                  emit(8'h21); emit(pick(ib));
                  emit(8'(op));
                  emit(8'h24); emit(8'h40);
                  halt();
                  go(32);
                  chk({tag, " result"}, acc, e[7:0]);
                  chk({tag, " carry"}, carry, e[9]);
                  chk({tag, " zero"}, zero, e[8]);
                  chk("R6 swept store", dmem[8'h40], e[7:0]);
               end
            end
         end
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule